// File: doc/BRIEF.md
# Sector Erase Sequencer with Suspend

This block runs the self-timed erase and program algorithms of a parallel flash array once an upstream command decoder has recognised a complete command. A sector erase first opens a short acceptance window in which more sector numbers may be added. When the window runs out, every selected sector gets the same treatment, lowest index first. The sector is programmed to zero and verified, then erased with timed pulses until a verify passes. A chip erase does the same for all sectors but uses a longer erase pulse.

A running sector erase can be paused so the host can read the array or program a byte in a sector that is not part of the erase. The erase then continues where it stopped. Every algorithm counts its pulses. If a verify still fails once the limit is reached, the block holds a failed, busy state until a reset command clears it.

Pulse and window lengths are counted in ticks of a one-microsecond strobe. The array outputs are level strobes that the analog drivers follow. The verify result comes back on an input that is sampled in the verify cycle.

Top module: `erase_sequencer`

## Requirements
- R1: After `rst`, and whenever `rst` is high, `busy`, `suspended`, `window_open`, `fail`, `arr_prog`, `arr_erase` and `arr_verify` are all 0.
- R2: `cmd_sec_erase` in the idle state opens the window for the sector on `sector_idx`. With no further load, `window_open` is high for exactly `WIN_US` ticks, and then the pre-program pulse of the lowest selected sector starts.
- R3: A `cmd_load` during the window adds its sector to the selection and restarts the `WIN_US` count from that strobe.
- R4: During the window, any other command (`cmd_reset`, `cmd_other`, `cmd_chip_erase`, `cmd_program`, `cmd_sec_erase`) drops the selection and returns to idle. No array pulse follows.
- R5: Each sector gets pre-program pulses of `PROG_US` ticks, each followed by a verify, then erase pulses each followed by a verify. An erase pulse lasts `ERASE_US` ticks for a sector erase and `CHIP_US` ticks for a chip erase, and a chip erase covers all `NSEC` sectors.
- R6: Selected sectors are erased one after another in ascending index order, whatever order they were loaded in.
- R7: `cmd_suspend` during the window or during a running sector erase gives `suspended`=1 and `busy`=0 in the next cycle, with all array strobes low. During a chip erase or a byte program it is ignored.
- R8: While suspended, `cmd_program` to a sector outside the selection runs a normal program with `busy`=1 and `suspended`=1, and then returns to the suspended state. A program to a selected sector, and any reset or other command, is ignored.
- R9: `cmd_load` while suspended resumes the erase, giving `busy`=1 and `suspended`=0. `cmd_load` in the idle state has no effect. A resumed erase can be suspended again.
- R10: A failed verify after `MAX_PULSES` pulses of one phase sets `fail`=1 with `busy`=1. This holds through any command except `cmd_reset`, which returns to idle.
- R11: `cmd_program` in the idle state gives program pulses of `PROG_US` ticks, each followed by a verify. A passing verify returns to idle with `fail`=0.
- R12: At most one of `arr_prog`, `arr_erase` and `arr_verify` is high at a time, and `arr_verify` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle strobe per microsecond |
| cmd_sec_erase | input | 1 | Decoded sector erase command (first sector) |
| cmd_load | input | 1 | Single-cycle sector load / erase resume command |
| cmd_chip_erase | input | 1 | Decoded chip erase command |
| cmd_program | input | 1 | Decoded byte program command |
| cmd_suspend | input | 1 | Erase suspend command |
| cmd_reset | input | 1 | Reset-to-read command |
| cmd_other | input | 1 | Any other decoded command |
| sector_idx | input | SW | Sector number carried with the command |
| verify_ok | input | 1 | Array verify result, sampled while `arr_verify` is high |
| busy | output | 1 | An algorithm or the load window is active |
| suspended | output | 1 | A sector erase is paused |
| window_open | output | 1 | Sector loads are still being accepted |
| fail | output | 1 | Pulse limit exceeded |
| arr_prog | output | 1 | Program pulse to the array |
| arr_erase | output | 1 | Erase pulse to the array |
| arr_verify | output | 1 | Verify strobe to the array |
| arr_sector | output | SW | Sector the array strobes apply to |

## Verification
The assertions watch, on every cycle, the exclusivity and single-cycle width of the array strobes and the persistence of the failed state until a reset command. They also cover the window closing on a foreign command or a suspend, the absence of array activity while paused, and that a stray load in the idle state starts nothing. Only the bench scenarios can show the exact window and pulse lengths, the retriggered window, the ascending erase order, the number of pulses spent before the limit trips, and the full suspend, side-program and resume sequence.

// File: rtl/erseq_pkg.sv
package erseq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WINDOW,
    ST_PRE,
    ST_PREVFY,
    ST_ERASE,
    ST_ERVFY,
    ST_SUSP,
    ST_PROG,
    ST_PRGVFY,
    ST_FAIL
  } seq_state_t;
endpackage

// File: rtl/erseq_timer.sv
// Tick counter: expire pulses on the tick that completes `limit` ticks.
module erseq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         expire
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (tick)    cnt <= cnt + W'(1);
  end

  assign expire = tick && !clear && (cnt == limit - W'(1));
endmodule

// File: rtl/erseq_pick.sv
// Lowest set bit of a sector mask.
module erseq_pick #(
  parameter int N  = 7,
  parameter int SW = 3
) (
  input  logic [N-1:0]  mask,
  output logic [SW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) idx = SW'(i);
    end
  end
  assign any = |mask;
endmodule

// File: rtl/erase_sequencer.sv
module erase_sequencer
  import erseq_pkg::*;
#(
  parameter int NSEC       = 7,
  parameter int WIN_US     = 30,
  parameter int PROG_US    = 7,
  parameter int ERASE_US   = 1000,
  parameter int CHIP_US    = 10000,
  parameter int MAX_PULSES = 16,
  localparam int SW        = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          us_tick,
  input  logic          cmd_sec_erase,
  input  logic          cmd_load,
  input  logic          cmd_chip_erase,
  input  logic          cmd_program,
  input  logic          cmd_suspend,
  input  logic          cmd_reset,
  input  logic          cmd_other,
  input  logic [SW-1:0] sector_idx,
  input  logic          verify_ok,
  output logic          busy,
  output logic          suspended,
  output logic          window_open,
  output logic          fail,
  output logic          arr_prog,
  output logic          arr_erase,
  output logic          arr_verify,
  output logic [SW-1:0] arr_sector
);
  localparam int TA   = (WIN_US > PROG_US) ? WIN_US : PROG_US;
  localparam int TB   = (ERASE_US > CHIP_US) ? ERASE_US : CHIP_US;
  localparam int TMAX = (TA > TB) ? TA : TB;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int CW   = $clog2(MAX_PULSES + 1);

  seq_state_t    state, state_n;
  logic [NSEC-1:0] mask, mask_n;
  logic [SW-1:0]   cur, cur_n, psec, psec_n;
  logic            chip, chip_n, pre_done, pre_done_n, sflag, sflag_n;
  logic [CW-1:0]   ecnt, ecnt_n, gcnt, gcnt_n;

  logic [NSEC-1:0] sel_bit, cur_bit, pick_in;
  logic [SW-1:0]   pick_idx;
  logic            pick_any, win_exp, pls_exp, is_pulse, sel_taken;
  logic [TW-1:0]   pulse_len;

  assign sel_bit   = NSEC'(1) << sector_idx;
  assign cur_bit   = NSEC'(1) << cur;
  assign sel_taken = |(mask & sel_bit);
  assign pick_in   = (state == ST_ERVFY) ? (mask & ~cur_bit) : mask;
  assign is_pulse  = (state == ST_PRE) || (state == ST_ERASE) || (state == ST_PROG);

  always_comb begin
    if (state == ST_ERASE) pulse_len = chip ? TW'(CHIP_US) : TW'(ERASE_US);
    else                   pulse_len = TW'(PROG_US);
  end

  erseq_pick #(.N(NSEC), .SW(SW)) i_pick (
    .mask(pick_in), .idx(pick_idx), .any(pick_any)
  );

  erseq_timer #(.W(TW)) i_win_tmr (
    .clk(clk), .rst(rst), .clear((state != ST_WINDOW) || cmd_load),
    .tick(us_tick), .limit(TW'(WIN_US)), .expire(win_exp)
  );

  erseq_timer #(.W(TW)) i_pls_tmr (
    .clk(clk), .rst(rst), .clear(!is_pulse),
    .tick(us_tick), .limit(pulse_len), .expire(pls_exp)
  );

  always_comb begin
    state_n    = state;
    mask_n     = mask;
    cur_n      = cur;
    psec_n     = psec;
    chip_n     = chip;
    pre_done_n = pre_done;
    sflag_n    = sflag;
    ecnt_n     = ecnt;
    gcnt_n     = gcnt;
    case (state)
      ST_IDLE: begin
        if (cmd_sec_erase) begin
          state_n = ST_WINDOW;
          mask_n  = sel_bit;
          chip_n  = 1'b0;
        end else if (cmd_chip_erase) begin
          state_n = ST_PRE;
          mask_n  = '1;
          chip_n  = 1'b1;
          cur_n   = '0;
          pre_done_n = 1'b0;
          ecnt_n  = '0;
        end else if (cmd_program) begin
          state_n = ST_PROG;
          psec_n  = sector_idx;
          gcnt_n  = '0;
          sflag_n = 1'b0;
        end
      end
      ST_WINDOW: begin
        if (cmd_suspend) begin
          state_n    = pick_any ? ST_SUSP : ST_IDLE;
          cur_n      = pick_idx;
          pre_done_n = 1'b0;
          ecnt_n     = '0;
        end else if (cmd_load) begin
          mask_n = mask | sel_bit;
        end else if (cmd_reset || cmd_other || cmd_chip_erase || cmd_program || cmd_sec_erase) begin
          state_n = ST_IDLE;
          mask_n  = '0;
        end else if (win_exp) begin
          state_n    = pick_any ? ST_PRE : ST_IDLE;
          cur_n      = pick_idx;
          pre_done_n = 1'b0;
          ecnt_n     = '0;
        end
      end
      ST_PRE, ST_ERASE: begin
        if (cmd_suspend && !chip) begin
          state_n = ST_SUSP;
        end else if (pls_exp) begin
          ecnt_n  = ecnt + CW'(1);
          state_n = (state == ST_PRE) ? ST_PREVFY : ST_ERVFY;
        end
      end
      ST_PREVFY: begin
        if (cmd_suspend && !chip) begin
          state_n = ST_SUSP;
        end else if (verify_ok) begin
          state_n    = ST_ERASE;
          pre_done_n = 1'b1;
          ecnt_n     = '0;
        end else begin
          state_n = (ecnt >= CW'(MAX_PULSES)) ? ST_FAIL : ST_PRE;
        end
      end
      ST_ERVFY: begin
        if (cmd_suspend && !chip) begin
          state_n = ST_SUSP;
        end else if (verify_ok) begin
          mask_n = pick_in;
          if (pick_any) begin
            state_n    = ST_PRE;
            cur_n      = pick_idx;
            pre_done_n = 1'b0;
            ecnt_n     = '0;
          end else begin
            state_n = ST_IDLE;
            chip_n  = 1'b0;
          end
        end else begin
          state_n = (ecnt >= CW'(MAX_PULSES)) ? ST_FAIL : ST_ERASE;
        end
      end
      ST_SUSP: begin
        if (cmd_load) begin
          state_n = pre_done ? ST_ERASE : ST_PRE;
        end else if (cmd_program && !sel_taken) begin
          state_n = ST_PROG;
          psec_n  = sector_idx;
          gcnt_n  = '0;
          sflag_n = 1'b1;
        end
      end
      ST_PROG: begin
        if (pls_exp) begin
          gcnt_n  = gcnt + CW'(1);
          state_n = ST_PRGVFY;
        end
      end
      ST_PRGVFY: begin
        if (verify_ok) state_n = sflag ? ST_SUSP : ST_IDLE;
        else           state_n = (gcnt >= CW'(MAX_PULSES)) ? ST_FAIL : ST_PROG;
      end
      ST_FAIL: begin
        if (cmd_reset) begin
          state_n = ST_IDLE;
          mask_n  = '0;
          chip_n  = 1'b0;
          sflag_n = 1'b0;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mask     <= '0;
      cur      <= '0;
      psec     <= '0;
      chip     <= 1'b0;
      pre_done <= 1'b0;
      sflag    <= 1'b0;
      ecnt     <= '0;
      gcnt     <= '0;
    end else begin
      state    <= state_n;
      mask     <= mask_n;
      cur      <= cur_n;
      psec     <= psec_n;
      chip     <= chip_n;
      pre_done <= pre_done_n;
      sflag    <= sflag_n;
      ecnt     <= ecnt_n;
      gcnt     <= gcnt_n;
    end
  end

  // Outputs decode the state register only, so they change right after the clock edge.
  assign busy        = (state != ST_IDLE) && (state != ST_SUSP);
  assign suspended   = (state == ST_SUSP) || (sflag && ((state == ST_PROG) || (state == ST_PRGVFY)));
  assign window_open = (state == ST_WINDOW);
  assign fail        = (state == ST_FAIL);
  assign arr_prog    = (state == ST_PRE) || (state == ST_PROG);
  assign arr_erase   = (state == ST_ERASE);
  assign arr_verify  = (state == ST_PREVFY) || (state == ST_ERVFY) || (state == ST_PRGVFY);
  assign arr_sector  = ((state == ST_PROG) || (state == ST_PRGVFY)) ? psec : cur;
endmodule

// File: rtl/erseq_checker.sv
module erseq_checker (
  input logic clk,
  input logic rst,
  input logic cmd_sec_erase,
  input logic cmd_load,
  input logic cmd_chip_erase,
  input logic cmd_program,
  input logic cmd_suspend,
  input logic cmd_reset,
  input logic cmd_other,
  input logic busy,
  input logic suspended,
  input logic window_open,
  input logic fail,
  input logic arr_prog,
  input logic arr_erase,
  input logic arr_verify
);
  a_r12_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({arr_prog, arr_erase, arr_verify}));

  a_r12_verify_single: assert property (@(posedge clk) disable iff (rst)
    arr_verify |=> !arr_verify);

  a_r10_fail_holds: assert property (@(posedge clk) disable iff (rst)
    fail && !cmd_reset |=> fail);

  a_r10_fail_busy: assert property (@(posedge clk) disable iff (rst)
    fail |-> busy);

  a_r4_other_closes: assert property (@(posedge clk) disable iff (rst)
    window_open && cmd_other && !cmd_load && !cmd_suspend |=> !window_open && !busy);

  a_r7_suspend_window: assert property (@(posedge clk) disable iff (rst)
    window_open && cmd_suspend |=> !window_open && !busy);

  a_r7_suspend_quiet: assert property (@(posedge clk) disable iff (rst)
    suspended && !busy |-> !arr_prog && !arr_erase && !arr_verify);

  a_r5_erase_unsuspended: assert property (@(posedge clk) disable iff (rst)
    arr_erase |-> !suspended);

  a_r9_idle_load: assert property (@(posedge clk) disable iff (rst)
    !busy && !suspended && cmd_load && !cmd_sec_erase && !cmd_chip_erase && !cmd_program
    |=> !busy);
endmodule

bind erase_sequencer erseq_checker i_chk (
  .clk(clk), .rst(rst), .cmd_sec_erase(cmd_sec_erase), .cmd_load(cmd_load),
  .cmd_chip_erase(cmd_chip_erase), .cmd_program(cmd_program),
  .cmd_suspend(cmd_suspend), .cmd_reset(cmd_reset), .cmd_other(cmd_other),
  .busy(busy), .suspended(suspended), .window_open(window_open), .fail(fail),
  .arr_prog(arr_prog), .arr_erase(arr_erase), .arr_verify(arr_verify)
);

// File: tb/test_erase_sequencer.sv
module test_erase_sequencer;
  localparam int NSEC = 7, WIN_US = 6, PROG_US = 2, ERASE_US = 3, CHIP_US = 5, MAXP = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, us_tick = 1'b1;
  logic cmd_sec_erase = 0, cmd_load = 0, cmd_chip_erase = 0, cmd_program = 0;
  logic cmd_suspend = 0, cmd_reset = 0, cmd_other = 0;
  logic [2:0] sector_idx = '0;
  logic verify_ok = 1'b1;
  logic busy, suspended, window_open, fail, arr_prog, arr_erase, arr_verify;
  logic [2:0] arr_sector;

  erase_sequencer #(.NSEC(NSEC), .WIN_US(WIN_US), .PROG_US(PROG_US), .ERASE_US(ERASE_US),
                    .CHIP_US(CHIP_US), .MAX_PULSES(MAXP)) i_erase_sequencer (
    .clk(clk), .rst(rst), .us_tick(us_tick), .cmd_sec_erase(cmd_sec_erase),
    .cmd_load(cmd_load), .cmd_chip_erase(cmd_chip_erase), .cmd_program(cmd_program),
    .cmd_suspend(cmd_suspend), .cmd_reset(cmd_reset), .cmd_other(cmd_other),
    .sector_idx(sector_idx), .verify_ok(verify_ok), .busy(busy), .suspended(suspended),
    .window_open(window_open), .fail(fail), .arr_prog(arr_prog), .arr_erase(arr_erase),
    .arr_verify(arr_verify), .arr_sector(arr_sector));

  int errors = 0, checks = 0, cycles = 0;
  int er_rises = 0, pr_rises = 0, er_len = 0, er_last = 0, pr_len = 0, pr_last = 0;
  int order [0:15];
  int nfail = 0, ecount = 0;
  bit prev_er = 0, prev_pr = 0, last_erase = 0, pre_ok = 1;

  // {sector[2:0], failing erase verifies[3:0], expect fail, expected erase pulses[3:0]}
  localparam logic [11:0] VEC [0:3] = '{
    {3'd0, 4'd0, 1'b0, 4'd1},
    {3'd6, 4'd2, 1'b0, 4'd3},
    {3'd3, 4'd3, 1'b1, 4'd3},
    {3'd4, 4'd1, 1'b0, 4'd2}
  };

  // Monitor and verify-result model, evaluated on the falling edge.
  always @(negedge clk) begin
    cycles++;
    if (arr_erase) begin
      if (!prev_er) begin
        if (er_rises < 16) order[er_rises] = int'(arr_sector);
        er_rises++;
        er_len = 0;
      end
      er_len++;
      last_erase = 1;
    end else if (prev_er) er_last = er_len;
    if (arr_prog) begin
      if (!prev_pr) begin pr_rises++; pr_len = 0; end
      pr_len++;
      last_erase = 0;
    end else if (prev_pr) pr_last = pr_len;
    if (arr_verify) begin
      if (last_erase) begin verify_ok = (ecount >= nfail); ecount++; end
      else verify_ok = pre_ok;
    end
    prev_er = arr_erase;
    prev_pr = arr_prog;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // 0 sec_erase, 1 load, 2 chip, 3 program, 4 suspend, 5 reset, 6 other
  task automatic issue(int which, int idx);
    sector_idx = 3'(idx);
    case (which)
      0: cmd_sec_erase = 1;
      1: cmd_load = 1;
      2: cmd_chip_erase = 1;
      3: cmd_program = 1;
      4: cmd_suspend = 1;
      5: cmd_reset = 1;
      default: cmd_other = 1;
    endcase
    step();
    {cmd_sec_erase, cmd_load, cmd_chip_erase, cmd_program, cmd_suspend, cmd_reset, cmd_other} = '0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && busy && !fail; i++) step();
  endtask

  task automatic wait_erase();
    for (int i = 0; i < 500 && !arr_erase; i++) step();
  endtask

  task automatic chk_quiet(string req);
    chk(req, "busy", busy, 0);
    chk(req, "suspended", suspended, 0);
    chk(req, "window_open", window_open, 0);
    chk(req, "fail", fail, 0);
    chk(req, "strobes", {arr_prog, arr_erase, arr_verify}, 0);
  endtask

  initial begin
    repeat (3) step();
    chk_quiet("R1");
    rst = 0;
    step();
    chk_quiet("R1");

    // Table of single-sector erases with forced verify failures (R5, R10)
    for (int v = 0; v < 4; v++) begin
      nfail = int'(VEC[v][8:5]);
      ecount = 0; er_rises = 0; pre_ok = 1;
      issue(0, int'(VEC[v][11:9]));
      wait_done();
      chk("R10", "fail", fail, int'(VEC[v][4]));
      chk("R5", "erase pulses", er_rises, int'(VEC[v][3:0]));
      chk("R5", "erased sector", order[0], int'(VEC[v][11:9]));
      if (VEC[v][4]) begin
        repeat (3) step();
        chk("R10", "fail held", fail, 1);
        chk("R10", "busy held", busy, 1);
        issue(5, 0);
      end else chk("R5", "erase pulse length", er_last, ERASE_US);
      chk_quiet("R10");
    end
    nfail = 0;

    // Window length without reload (R2)
    issue(0, 3);
    chk("R2", "window opened", window_open, 1);
    repeat (5) step();
    chk("R2", "still open", window_open, 1);
    step();
    chk("R2", "window closed", window_open, 0);
    chk("R2", "pre-program started", arr_prog, 1);
    wait_done();

    // Retriggered window and ascending order (R3, R6)
    er_rises = 0;
    issue(0, 5);
    step(); step();
    issue(1, 1);
    repeat (3) step();
    chk("R3", "open past first expiry", window_open, 1);
    repeat (2) step();
    chk("R3", "open before new expiry", window_open, 1);
    step();
    chk("R3", "closed at new expiry", window_open, 0);
    wait_done();
    chk("R6", "sectors erased", er_rises, 2);
    chk("R6", "first sector", order[0], 1);
    chk("R6", "second sector", order[1], 5);

    // Foreign command in window (R4)
    er_rises = 0; pr_rises = 0;
    issue(0, 2);
    issue(6, 0);
    chk("R4", "window after other", window_open, 0);
    chk("R4", "busy after other", busy, 0);
    repeat (20) step();
    chk("R4", "no array pulses", er_rises + pr_rises, 0);

    // Chip erase, suspend ignored (R5, R7)
    er_rises = 0;
    issue(2, 0);
    wait_erase();
    issue(4, 0);
    chk("R7", "chip erase not suspended", suspended, 0);
    chk("R7", "chip erase still busy", busy, 1);
    wait_done();
    chk("R5", "chip erase pulses", er_rises, NSEC);
    chk("R5", "chip pulse length", er_last, CHIP_US);
    chk("R6", "chip last sector", order[NSEC-1], NSEC - 1);

    // Suspend, side program, resume, suspend again (R7, R8, R9)
    nfail = 1; ecount = 0;
    issue(0, 2);
    wait_erase();
    issue(4, 0);
    chk("R7", "suspended", suspended, 1);
    chk("R7", "not busy", busy, 0);
    chk("R7", "strobes idle", {arr_prog, arr_erase, arr_verify}, 0);
    issue(3, 2);
    chk("R8", "program to erased sector ignored", busy, 0);
    issue(5, 0);
    chk("R8", "reset ignored", suspended, 1);
    pr_rises = 0;
    issue(3, 4);
    chk("R8", "side program busy", busy, 1);
    chk("R8", "side program pulse", arr_prog, 1);
    chk("R8", "side program suspended", suspended, 1);
    wait_done();
    chk("R8", "back to suspend", suspended, 1);
    chk("R8", "one program pulse", pr_rises, 1);
    issue(1, 0);
    chk("R9", "resume busy", busy, 1);
    chk("R9", "resume suspended", suspended, 0);
    step();
    issue(4, 0);
    chk("R9", "suspend again", suspended, 1);
    issue(1, 0);
    wait_done();
    chk("R9", "erase finished", busy | suspended | fail, 0);
    nfail = 0;

    // Suspend during the window (R7)
    issue(0, 5);
    issue(4, 0);
    chk("R7", "window suspended", suspended, 1);
    chk("R7", "window closed by suspend", window_open, 0);
    issue(1, 0);
    chk("R9", "resume into pre-program", arr_prog, 1);
    wait_done();

    // Load with no suspend pending (R9)
    issue(1, 3);
    chk("R9", "idle load busy", busy, 0);
    chk("R9", "idle load window", window_open, 0);

    // Byte program, pass then fail (R11, R10)
    pr_rises = 0; pre_ok = 1;
    issue(3, 1);
    chk("R11", "program busy", busy, 1);
    wait_done();
    chk("R11", "program pulse length", pr_last, PROG_US);
    chk("R11", "program pulses", pr_rises, 1);
    chk("R11", "program fail flag", fail, 0);
    pr_rises = 0; pre_ok = 0;
    issue(3, 1);
    wait_done();
    chk("R10", "program fail", fail, 1);
    chk("R10", "program pulses at limit", pr_rises, MAXP);
    issue(6, 0);
    chk("R10", "fail kept after other", fail, 1);
    issue(5, 0);
    chk("R10", "reset clears fail", fail, 0);
    chk("R10", "reset clears busy", busy, 0);
    pre_ok = 1;

    // Reset in the middle of an erase (R1)
    issue(0, 0);
    wait_erase();
    rst = 1;
    step();
    chk_quiet("R1");
    rst = 0;
    step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule